// File: doc/BRIEF.md
# Speculative Reorder Buffer

This block keeps instructions in program order while their results arrive in any order. The issue stage allocates the entry at the tail and receives that entry's index as the instruction's tag. At allocation the block records the instruction kind, the destination register, the predicted branch direction and the store address. Execution units later broadcast a result with its tag on a shared result bus. The entry with that index takes the value, takes the actual branch direction and becomes ready.

Only the oldest entry, at the head, may retire, and only once it is ready. What happens at retirement depends on the entry kind. A plain operation writes its destination register. A store writes its address and data to memory. A branch whose prediction proves wrong discards every entry and sends fetch to the corrected address. A correctly predicted branch retires with no further action. Two lookup ports let the issue stage read a completed value that has not yet retired, so a dependent instruction can pick up its operand early.

Top module: `rob_core`

## Requirements
- R1: With all DEPTH (default 8) entries occupied, `rob_full` is high and `issue_valid` is ignored: `issue_tag` and `rob_count` do not change.
- R2: An accepted issue (`issue_valid` high, not full, no flush in that cycle) takes the entry numbered `issue_tag`, and the next tag is `issue_tag + 1` modulo DEPTH.
- R3: `rob_count` equals the number of occupied entries and never exceeds DEPTH.
- R4: A result with `res_valid` high stores `res_value` and `res_taken` in the occupied entry whose index equals `res_tag`, and marks that entry ready. Results may arrive in any order.
- R5: Entries retire strictly in allocation order, at most one per cycle, and only when the head entry is ready. A kind 0 (register operation) entry pulses `rf_we` for one cycle, carrying its destination in `rf_waddr` and its value in `rf_wdata`, on the cycle after the retiring clock edge.
- R6: A kind 1 (store) entry writes nothing to a register at retirement. Instead it pulses `mem_we`, with `mem_addr` set to the address recorded at issue and `mem_wdata` set to the broadcast value.
- R7: When a kind 2 (branch) entry retires with `res_taken` different from its predicted direction, `redirect_valid` pulses and `redirect_pc` carries the branch's broadcast value. Every younger entry is discarded without retiring, `rob_count` becomes 0, and the next tag is the branch's tag + 1 modulo DEPTH.
- R8: A kind 2 entry whose `res_taken` matches its prediction retires with no register write, no memory write and no redirect.
- R9: Lookup port i reports `lk_ready[i]` high and returns the stored value only when the entry named by its tag is occupied and ready. Otherwise `lk_ready[i]` is low.
- R10: An issue request in the same cycle as a misprediction flush is not allocated.
- R11: After reset the buffer is empty: `rob_count` is 0, `rob_full` is low, `issue_tag` is 0 and no write or redirect strobe is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | Request to allocate an entry |
| issue_kind | input | 2 | 0 register op, 1 store, 2 branch |
| issue_dest | input | REG_W | Destination register of a register op |
| issue_pred_taken | input | 1 | Predicted direction of a branch |
| issue_addr | input | ADDR_W | Memory address of a store |
| rob_full | output | 1 | All entries occupied; issue stalls |
| issue_tag | output | TAG_W | Index the next allocation receives |
| rob_count | output | CNT_W | Number of occupied entries |
| res_valid | input | 1 | Result broadcast valid |
| res_tag | input | TAG_W | Entry index of the broadcast |
| res_value | input | DATA_W | Result value (corrected target for a branch) |
| res_taken | input | 1 | Actual direction of a branch |
| lk_tag | input | NLK*TAG_W | Lookup tags, port i in bits [i*TAG_W +: TAG_W] |
| lk_ready | output | NLK | Looked-up entry holds a completed value |
| lk_value | output | NLK*DATA_W | Looked-up values |
| rf_we | output | 1 | Register write strobe |
| rf_waddr | output | REG_W | Register write address |
| rf_wdata | output | DATA_W | Register write data |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory write address |
| mem_wdata | output | DATA_W | Memory write data |
| redirect_valid | output | 1 | Fetch redirect strobe |
| redirect_pc | output | ADDR_W | Corrected fetch address |

## Verification
The bench completes results in reverse and scrambled order. A design that retired whatever finished first would write registers out of order, or would retire the head before its result existed. The bench also completes the instructions behind a mispredicted branch before the branch itself, and tries to issue in the flush cycle. A design that missed younger entries or accepted that allocation would then emit stray writes or report a nonzero count. The buffer is filled across the index wrap, and an extra issue is attempted while full: a wrong stall would corrupt the tag sequence, the occupancy, or the oldest entry. The bench also reads the lookup ports with one entry completed and one pending, which exposes a lookup that ignores the ready state.

// File: rtl/rob_pkg.sv
package rob_pkg;

  typedef enum logic [1:0] {
    KIND_REG    = 2'd0,
    KIND_STORE  = 2'd1,
    KIND_BRANCH = 2'd2,
    KIND_RSVD   = 2'd3
  } rob_kind_e;

endpackage

// File: rtl/rob_ptrs.sv
// Head/tail pointers and occupancy counter of the circular buffer.
module rob_ptrs #(
  parameter int DEPTH = 8,
  parameter int TAG_W = $clog2(DEPTH),
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             alloc,
  input  logic             commit,
  input  logic             flush,
  output logic [TAG_W-1:0] head,
  output logic [TAG_W-1:0] tail,
  output logic [CNT_W-1:0] count,
  output logic             full
);

  function automatic logic [TAG_W-1:0] bump(input logic [TAG_W-1:0] p);
    return (p == TAG_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else if (flush) begin
      // the mispredicted branch itself retires; everything younger is gone
      head  <= bump(head);
      tail  <= bump(head);
      count <= '0;
    end else begin
      if (commit) head <= bump(head);
      if (alloc)  tail <= bump(tail);
      case ({alloc, commit})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign full = (count == CNT_W'(DEPTH));

endmodule

// File: rtl/rob_entries.sv
// Entry storage: state bits in flops, payload in plain arrays.
module rob_entries
  import rob_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int TAG_W  = $clog2(DEPTH),
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int REG_W  = 5,
  parameter int NLK    = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  alloc,
  input  logic [TAG_W-1:0]      alloc_idx,
  input  rob_kind_e             alloc_kind,
  input  logic [REG_W-1:0]      alloc_dest,
  input  logic                  alloc_pred,
  input  logic [ADDR_W-1:0]     alloc_addr,
  input  logic                  bc_valid,
  input  logic [TAG_W-1:0]      bc_tag,
  input  logic [DATA_W-1:0]     bc_value,
  input  logic                  bc_taken,
  input  logic                  retire,
  input  logic                  flush,
  input  logic [TAG_W-1:0]      head_idx,
  input  logic [NLK*TAG_W-1:0]  lk_tag,
  output logic [NLK-1:0]        lk_ready,
  output logic [NLK*DATA_W-1:0] lk_value,
  output logic                  hd_valid,
  output logic                  hd_ready,
  output rob_kind_e             hd_kind,
  output logic [REG_W-1:0]      hd_dest,
  output logic [ADDR_W-1:0]     hd_addr,
  output logic [DATA_W-1:0]     hd_value,
  output logic                  hd_mispred
);

  logic [DEPTH-1:0]  vld_q;
  logic [DEPTH-1:0]  rdy_q;
  logic [DEPTH-1:0]  pred_q;
  logic [DEPTH-1:0]  taken_q;
  rob_kind_e         kind_q [DEPTH];
  logic [REG_W-1:0]  dest_q [DEPTH];
  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [DATA_W-1:0] val_q  [DEPTH];

  logic bc_hit;
  assign bc_hit = bc_valid & vld_q[bc_tag];

  // state bits: cleared as a whole on flush
  always_ff @(posedge clk) begin
    if (rst || flush) begin
      vld_q <= '0;
      rdy_q <= '0;
    end else begin
      if (retire) vld_q[head_idx] <= 1'b0;
      if (bc_hit) rdy_q[bc_tag]   <= 1'b1;
      if (alloc) begin
        vld_q[alloc_idx] <= 1'b1;
        rdy_q[alloc_idx] <= 1'b0;
      end
    end
  end

  // payload: no reset, single write per array per port
  always_ff @(posedge clk) begin
    if (alloc) begin
      kind_q[alloc_idx] <= alloc_kind;
      dest_q[alloc_idx] <= alloc_dest;
      addr_q[alloc_idx] <= alloc_addr;
      pred_q[alloc_idx] <= alloc_pred;
    end
    if (bc_hit) begin
      val_q[bc_tag]   <= bc_value;
      taken_q[bc_tag] <= bc_taken;
    end
  end

  generate
    for (genvar g = 0; g < NLK; g++) begin : g_lookup
      logic [TAG_W-1:0] t;
      assign t = lk_tag[g*TAG_W +: TAG_W];
      assign lk_ready[g] = vld_q[t] & rdy_q[t];
      assign lk_value[g*DATA_W +: DATA_W] = val_q[t];
    end
  endgenerate

  assign hd_valid   = vld_q[head_idx];
  assign hd_ready   = rdy_q[head_idx];
  assign hd_kind    = kind_q[head_idx];
  assign hd_dest    = dest_q[head_idx];
  assign hd_addr    = addr_q[head_idx];
  assign hd_value   = val_q[head_idx];
  assign hd_mispred = pred_q[head_idx] ^ taken_q[head_idx];

endmodule

// File: rtl/rob_retire.sv
// Retirement decision at the head and registered commit interfaces.
module rob_retire
  import rob_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int REG_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hd_valid,
  input  logic              hd_ready,
  input  rob_kind_e         hd_kind,
  input  logic [REG_W-1:0]  hd_dest,
  input  logic [ADDR_W-1:0] hd_addr,
  input  logic [DATA_W-1:0] hd_value,
  input  logic              hd_mispred,
  output logic              retire,
  output logic              flush,
  output logic              rf_we,
  output logic [REG_W-1:0]  rf_waddr,
  output logic [DATA_W-1:0] rf_wdata,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              redirect_valid,
  output logic [ADDR_W-1:0] redirect_pc
);

  assign retire = hd_valid & hd_ready;
  assign flush  = retire & (hd_kind == KIND_BRANCH) & hd_mispred;

  always_ff @(posedge clk) begin
    if (rst) begin
      rf_we          <= 1'b0;
      rf_waddr       <= '0;
      rf_wdata       <= '0;
      mem_we         <= 1'b0;
      mem_addr       <= '0;
      mem_wdata      <= '0;
      redirect_valid <= 1'b0;
      redirect_pc    <= '0;
    end else begin
      rf_we          <= retire & (hd_kind == KIND_REG);
      rf_waddr       <= hd_dest;
      rf_wdata       <= hd_value;
      mem_we         <= retire & (hd_kind == KIND_STORE);
      mem_addr       <= hd_addr;
      mem_wdata      <= hd_value;
      redirect_valid <= flush;
      redirect_pc    <= hd_value[ADDR_W-1:0];
    end
  end

endmodule

// File: rtl/rob_core.sv
module rob_core
  import rob_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int REG_W  = 5,
  parameter int NLK    = 2,
  parameter int TAG_W  = $clog2(DEPTH),
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  issue_valid,
  input  logic [1:0]            issue_kind,
  input  logic [REG_W-1:0]      issue_dest,
  input  logic                  issue_pred_taken,
  input  logic [ADDR_W-1:0]     issue_addr,
  output logic                  rob_full,
  output logic [TAG_W-1:0]      issue_tag,
  output logic [CNT_W-1:0]      rob_count,
  input  logic                  res_valid,
  input  logic [TAG_W-1:0]      res_tag,
  input  logic [DATA_W-1:0]     res_value,
  input  logic                  res_taken,
  input  logic [NLK*TAG_W-1:0]  lk_tag,
  output logic [NLK-1:0]        lk_ready,
  output logic [NLK*DATA_W-1:0] lk_value,
  output logic                  rf_we,
  output logic [REG_W-1:0]      rf_waddr,
  output logic [DATA_W-1:0]     rf_wdata,
  output logic                  mem_we,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic [DATA_W-1:0]     mem_wdata,
  output logic                  redirect_valid,
  output logic [ADDR_W-1:0]     redirect_pc
);

  logic             alloc;
  logic             retire;
  logic             flush;
  logic [TAG_W-1:0] head;
  logic [TAG_W-1:0] tail;

  logic              hd_valid;
  logic              hd_ready;
  rob_kind_e         hd_kind;
  logic [REG_W-1:0]  hd_dest;
  logic [ADDR_W-1:0] hd_addr;
  logic [DATA_W-1:0] hd_value;
  logic              hd_mispred;

  // issue is dropped while full or while the buffer is being emptied
  assign alloc     = issue_valid & ~rob_full & ~flush;
  assign issue_tag = tail;

  rob_ptrs #(
    .DEPTH(DEPTH), .TAG_W(TAG_W), .CNT_W(CNT_W)
  ) u_ptrs (
    .clk    (clk),
    .rst    (rst),
    .alloc  (alloc),
    .commit (retire),
    .flush  (flush),
    .head   (head),
    .tail   (tail),
    .count  (rob_count),
    .full   (rob_full)
  );

  rob_entries #(
    .DEPTH(DEPTH), .TAG_W(TAG_W), .DATA_W(DATA_W),
    .ADDR_W(ADDR_W), .REG_W(REG_W), .NLK(NLK)
  ) u_entries (
    .clk        (clk),
    .rst        (rst),
    .alloc      (alloc),
    .alloc_idx  (tail),
    .alloc_kind (rob_kind_e'(issue_kind)),
    .alloc_dest (issue_dest),
    .alloc_pred (issue_pred_taken),
    .alloc_addr (issue_addr),
    .bc_valid   (res_valid),
    .bc_tag     (res_tag),
    .bc_value   (res_value),
    .bc_taken   (res_taken),
    .retire     (retire),
    .flush      (flush),
    .head_idx   (head),
    .lk_tag     (lk_tag),
    .lk_ready   (lk_ready),
    .lk_value   (lk_value),
    .hd_valid   (hd_valid),
    .hd_ready   (hd_ready),
    .hd_kind    (hd_kind),
    .hd_dest    (hd_dest),
    .hd_addr    (hd_addr),
    .hd_value   (hd_value),
    .hd_mispred (hd_mispred)
  );

  rob_retire #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .REG_W(REG_W)
  ) u_retire (
    .clk            (clk),
    .rst            (rst),
    .hd_valid       (hd_valid),
    .hd_ready       (hd_ready),
    .hd_kind        (hd_kind),
    .hd_dest        (hd_dest),
    .hd_addr        (hd_addr),
    .hd_value       (hd_value),
    .hd_mispred     (hd_mispred),
    .retire         (retire),
    .flush          (flush),
    .rf_we          (rf_we),
    .rf_waddr       (rf_waddr),
    .rf_wdata       (rf_wdata),
    .mem_we         (mem_we),
    .mem_addr       (mem_addr),
    .mem_wdata      (mem_wdata),
    .redirect_valid (redirect_valid),
    .redirect_pc    (redirect_pc)
  );

endmodule

// File: rtl/rob_core_chk.sv
module rob_core_chk #(
  parameter int DEPTH = 8,
  parameter int TAG_W = $clog2(DEPTH),
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             issue_valid,
  input logic             rob_full,
  input logic [TAG_W-1:0] issue_tag,
  input logic [CNT_W-1:0] rob_count,
  input logic             rf_we,
  input logic             mem_we,
  input logic             redirect_valid
);

  // R1: a full buffer accepts nothing
  a_r1_stall_when_full: assert property (@(posedge clk) disable iff (rst)
    rob_full |=> (rob_count <= $past(rob_count)));

  // R2: an accepted issue advances the tag by one, unless a flush intervened
  a_r2_tag_advance: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && !rob_full) |=>
      (redirect_valid ||
       issue_tag == (($past(issue_tag) == TAG_W'(DEPTH - 1)) ? '0 : $past(issue_tag) + 1'b1)));

  // R3: occupancy bounded
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
    rob_count <= CNT_W'(DEPTH));

  // R5: at most one retirement action per cycle
  a_r5_one_action: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rf_we, mem_we, redirect_valid}));

  // R7: a redirect leaves the buffer empty
  a_r7_flush_empties: assert property (@(posedge clk) disable iff (rst)
    redirect_valid |-> (rob_count == '0 && !rob_full));

endmodule

bind rob_core rob_core_chk #(
  .DEPTH(DEPTH), .TAG_W(TAG_W), .CNT_W(CNT_W)
) u_chk (
  .clk            (clk),
  .rst            (rst),
  .issue_valid    (issue_valid),
  .rob_full       (rob_full),
  .issue_tag      (issue_tag),
  .rob_count      (rob_count),
  .rf_we          (rf_we),
  .mem_we         (mem_we),
  .redirect_valid (redirect_valid)
);

// File: tb/rob_core_test.sv
module rob_core_test;

  localparam int DEPTH  = 8;
  localparam int TAG_W  = 3;
  localparam int CNT_W  = 4;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 32;
  localparam int REG_W  = 5;
  localparam int NLK    = 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic                  rst;
  logic                  issue_valid;
  logic [1:0]            issue_kind;
  logic [REG_W-1:0]      issue_dest;
  logic                  issue_pred_taken;
  logic [ADDR_W-1:0]     issue_addr;
  logic                  rob_full;
  logic [TAG_W-1:0]      issue_tag;
  logic [CNT_W-1:0]      rob_count;
  logic                  res_valid;
  logic [TAG_W-1:0]      res_tag;
  logic [DATA_W-1:0]     res_value;
  logic                  res_taken;
  logic [NLK*TAG_W-1:0]  lk_tag;
  logic [NLK-1:0]        lk_ready;
  logic [NLK*DATA_W-1:0] lk_value;
  logic                  rf_we;
  logic [REG_W-1:0]      rf_waddr;
  logic [DATA_W-1:0]     rf_wdata;
  logic                  mem_we;
  logic [ADDR_W-1:0]     mem_addr;
  logic [DATA_W-1:0]     mem_wdata;
  logic                  redirect_valid;
  logic [ADDR_W-1:0]     redirect_pc;

  rob_core uut (
    .clk(clk), .rst(rst),
    .issue_valid(issue_valid), .issue_kind(issue_kind), .issue_dest(issue_dest),
    .issue_pred_taken(issue_pred_taken), .issue_addr(issue_addr),
    .rob_full(rob_full), .issue_tag(issue_tag), .rob_count(rob_count),
    .res_valid(res_valid), .res_tag(res_tag), .res_value(res_value), .res_taken(res_taken),
    .lk_tag(lk_tag), .lk_ready(lk_ready), .lk_value(lk_value),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc)
  );

  typedef struct packed {
    logic [1:0]  kind;
    logic [31:0] a;
    logic [31:0] d;
  } exp_t;

  exp_t exp_q[$];
  exp_t got_m;
  exp_t exp_m;
  int   tests = 0;
  int   fails = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [95:0] act, input logic [95:0] expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // monitor: every retirement strobe is matched against the scoreboard
  always @(negedge clk) begin
    if (!rst && (rf_we || mem_we || redirect_valid)) begin
      got_m.kind = rf_we ? 2'd0 : (mem_we ? 2'd1 : 2'd2);
      got_m.a    = rf_we ? {27'b0, rf_waddr} : (mem_we ? mem_addr : redirect_pc);
      got_m.d    = rf_we ? rf_wdata : (mem_we ? mem_wdata : 32'd0);
      if (exp_q.size() == 0) begin
        check(1'b0, "R5", "unexpected retirement", {30'b0, got_m}, 96'd0);
      end else begin
        exp_m = exp_q.pop_front();
        check(got_m == exp_m,
              (exp_m.kind == 2'd0) ? "R5" : ((exp_m.kind == 2'd1) ? "R6" : "R7"),
              "retirement mismatch", {30'b0, got_m}, {30'b0, exp_m});
      end
    end
  end

  task automatic do_issue(input logic [1:0] k, input logic [4:0] d, input logic p,
                          input logic [31:0] a, output logic [2:0] tag);
    @(negedge clk);
    issue_valid = 1'b1; issue_kind = k; issue_dest = d;
    issue_pred_taken = p; issue_addr = a;
    tag = issue_tag;
    @(negedge clk);
    issue_valid = 1'b0;
  endtask

  task automatic do_bcast(input logic [2:0] tag, input logic [31:0] v, input logic tk);
    @(negedge clk);
    res_valid = 1'b1; res_tag = tag; res_value = v; res_taken = tk;
    @(negedge clk);
    res_valid = 1'b0;
  endtask

  task automatic push(input logic [1:0] k, input logic [31:0] a, input logic [31:0] d);
    exp_t e;
    e.kind = k; e.a = a; e.d = d;
    exp_q.push_back(e);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [2:0] t0, t1, t2, tb, ty;
    logic [2:0] tg [8];
    rst = 1'b1; issue_valid = 0; issue_kind = 0; issue_dest = 0;
    issue_pred_taken = 0; issue_addr = 0; res_valid = 0; res_tag = 0;
    res_value = 0; res_taken = 0; lk_tag = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R11 reset state
    check(rob_count == 0 && !rob_full && issue_tag == 0, "R11", "empty after reset",
          {rob_count, rob_full, issue_tag}, 96'd0);
    check(!rf_we && !mem_we && !redirect_valid, "R11", "strobes low after reset",
          {rf_we, mem_we, redirect_valid}, 96'd0);

    // R2 R4 R5: out-of-order completion, in-order retirement
    do_issue(2'd0, 5'd1, 1'b0, 32'd0, t0); push(2'd0, 32'd1, 32'h11);
    do_issue(2'd0, 5'd2, 1'b0, 32'd0, t1); push(2'd0, 32'd2, 32'h22);
    do_issue(2'd0, 5'd3, 1'b0, 32'd0, t2); push(2'd0, 32'd3, 32'h33);
    check(t0 == 0 && t1 == 1 && t2 == 2, "R2", "sequential tags", {t0, t1, t2}, {3'd0, 3'd1, 3'd2});
    check(rob_count == 3, "R3", "count after three issues", rob_count, 3);
    do_bcast(t2, 32'h33, 1'b0);
    repeat (3) @(negedge clk);
    check(rob_count == 3, "R5", "no retirement while head not ready", rob_count, 3);
    do_bcast(t0, 32'h11, 1'b0);
    do_bcast(t1, 32'h22, 1'b0);
    repeat (6) @(negedge clk);
    check(rob_count == 0, "R3", "drained after completion", rob_count, 0);

    // R9 lookup of completed vs pending entries
    do_issue(2'd0, 5'd4, 1'b0, 32'd0, t0); push(2'd0, 32'd4, 32'h4444);
    do_issue(2'd0, 5'd5, 1'b0, 32'd0, t1); push(2'd0, 32'd5, 32'h5555);
    do_bcast(t1, 32'h5555, 1'b0);
    @(negedge clk);
    lk_tag = {t0, t1};
    #1;
    check(lk_ready == 2'b01, "R9", "ready only for completed entry", lk_ready, 2'b01);
    check(lk_value[31:0] == 32'h5555, "R9", "lookup value", lk_value[31:0], 32'h5555);
    do_bcast(t0, 32'h4444, 1'b0);
    repeat (5) @(negedge clk);
    check(rob_count == 0, "R3", "drained after lookup test", rob_count, 0);

    // R6 store waits its turn, writes memory
    do_issue(2'd1, 5'd0, 1'b0, 32'h1000, t0); push(2'd1, 32'h1000, 32'hABCD);
    do_issue(2'd0, 5'd6, 1'b0, 32'd0, t1);    push(2'd0, 32'd6, 32'h66);
    do_bcast(t1, 32'h66, 1'b0);
    do_bcast(t0, 32'hABCD, 1'b0);
    repeat (5) @(negedge clk);
    check(rob_count == 0, "R6", "store retired", rob_count, 0);

    // R8 correctly predicted branch retires silently
    do_issue(2'd2, 5'd0, 1'b1, 32'd0, tb);
    do_issue(2'd0, 5'd7, 1'b0, 32'd0, t1); push(2'd0, 32'd7, 32'h77);
    do_bcast(t1, 32'h77, 1'b0);
    do_bcast(tb, 32'h2000, 1'b1);
    repeat (5) @(negedge clk);
    check(rob_count == 0 && exp_q.size() == 0, "R8", "branch retired without action",
          rob_count, 0);

    // R7 R10 mispredicted branch flush with an issue in the flush cycle
    do_issue(2'd0, 5'd8, 1'b0, 32'd0, t0); push(2'd0, 32'd8, 32'h88);
    do_issue(2'd2, 5'd0, 1'b0, 32'd0, tb); push(2'd2, 32'h3000, 32'd0);
    do_issue(2'd0, 5'd9, 1'b0, 32'd0, t1);
    do_issue(2'd0, 5'd10, 1'b0, 32'd0, ty);
    do_bcast(t1, 32'h99, 1'b0);
    do_bcast(ty, 32'haa, 1'b0);
    do_bcast(t0, 32'h88, 1'b0);
    repeat (3) @(negedge clk);
    check(rob_count == 3, "R5", "branch waits at head", rob_count, 3);
    @(negedge clk);
    res_valid = 1'b1; res_tag = tb; res_value = 32'h3000; res_taken = 1'b1;
    @(negedge clk);
    res_valid = 1'b0;
    issue_valid = 1'b1; issue_kind = 2'd0; issue_dest = 5'd11;
    @(negedge clk);
    issue_valid = 1'b0;
    check(rob_count == 0, "R10", "flush-cycle issue not allocated", rob_count, 0);
    check(issue_tag == tb + 3'd1, "R7", "tag after flush", issue_tag, tb + 3'd1);
    repeat (6) @(negedge clk);
    check(rob_count == 0 && exp_q.size() == 0, "R7", "younger entries discarded",
          exp_q.size(), 0);

    // R1 fill across wrap, extra issue ignored
    for (int i = 0; i < 8; i++) begin
      do_issue(2'd0, 5'(12 + i), 1'b0, 32'd0, tg[i]);
      push(2'd0, 32'(12 + i), 32'h100 + 32'(i));
    end
    check(rob_full && rob_count == 8, "R1", "full at depth", {rob_full, rob_count}, {1'b1, 4'd8});
    t2 = issue_tag;
    @(negedge clk);
    issue_valid = 1'b1; issue_kind = 2'd0; issue_dest = 5'd30;
    @(negedge clk);
    issue_valid = 1'b0;
    check(rob_count == 8 && issue_tag == t2, "R1", "issue ignored while full",
          {rob_count, issue_tag}, {4'd8, t2});
    for (int i = 7; i >= 0; i--) do_bcast(tg[i], 32'h100 + 32'(i), 1'b0);
    repeat (12) @(negedge clk);
    check(rob_count == 0 && !rob_full, "R3", "empty after full drain", rob_count, 0);
    check(exp_q.size() == 0, "R5", "all expected retirements seen", exp_q.size(), 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule